// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Register Block

This block is a watchdog timer with a small register file on a simple word bus: a 3-bit word address, 16-bit write data with two byte enables, and write and read strobes. Software programs a 10-bit timeout value and loads the live down-counter from it by writing the reload register. After that, the counter decrements once per `tick` pulse (one tick stands for 0.6 s) until software halts it.

When the counter expires, a first-timeout flag is set and the counter reloads from the timeout value, so counting goes on. If the counter expires again before software has cleared that flag, a second-timeout flag is set. Unless the `no_reboot` input is high, the block then also sets a boot-status flag and emits a one-cycle reset request. Status bits clear when 1 is written to them. A lock bit can only be set; reset clears it. Writes to either byte of the data port set a status bit, which software can use as a signal.

Top module: `twostage_wdt`

## Requirements
- R1: After reset the registers read: address 0 (counter) 0x0000, address 1 (timeout value) 0x0004, address 2 (status A) 0x0000, address 3 (status B) 0x0000, address 4 (control A) 0x0000, address 5 (control B) 0x0008, address 6 (data port) 0x0000, address 7 (misc: low byte software-IRQ, high byte count) 0x0003.
- R2: The timeout value at address 1 is 10 bits wide. Write bits 15:10 are ignored, so writing 0xFFFF with both byte enables reads back 0x03FF.
- R3: A write of any data to address 0 loads the counter from the timeout value. A read of address 0 returns the live counter in bits 9:0.
- R4: While the halt bit (bit 0 of address 4) is 1, ticks leave the counter unchanged. Writing it to 0 resumes counting.
- R5: With halt clear, every tick decrements the counter by one, so k ticks after a load the counter reads the loaded value minus k.
- R6: A tick that arrives while the counter is 1 or 0 is an expiry. It sets the timeout flag (bit 0 of address 2) and reloads the counter from the timeout value. With timeout value 0x3FF, 0x3FE ticks leave the counter at 1 with the flag still clear, and the next tick sets the flag.
- R7: An expiry that occurs while the timeout flag is already set also sets the second-timeout flag (bit 0 of address 3).
- R8: A second-timeout expiry with `no_reboot` low sets the boot-status flag (bit 1 of address 3) and drives `reset_req` high for exactly one cycle. With `no_reboot` high, neither happens.
- R9: Status bits clear when 1 is written to them. Writing back the value read from address 2 or address 3 leaves that register reading 0.
- R10: The lock bit (bit 1 of address 4) is set by writing it as 1. A later write of 0 leaves it set. Only reset clears it.
- R11: A write to the low byte of address 6 sets the software-signal flag (bit 1 of address 2). A write to the high byte sets the interrupt flag (bit 2 of address 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Word address |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enables for wdata |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe; rdata is valid on the next cycle |
| rdata | output | 16 | Read data |
| tick | input | 1 | Single-cycle count enable (one tick per 0.6 s) |
| no_reboot | input | 1 | When high, suppresses the reset request |
| reset_req | output | 1 | One-cycle reset request on a second timeout |

## Verification
The hardest state to reach is a second expiry while the first-timeout flag is still pending. It needs two full countdowns with no status clear in between, and it has to be reached twice, once with `no_reboot` high and once low. The bench programs a short timeout, runs twice that many ticks, and counts every cycle on which `reset_req` is high. This shows both that the pulse is absent when suppressed and that it lasts one cycle when allowed. The 0x3FF boundary is reached by running 0x3FE ticks and then reading the counter just before the final tick.

// File: rtl/twostage_wdt.sv
module twostage_wdt #(
  parameter int CW      = 10,
  parameter int TMR_RST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  input  logic [1:0]  be,
  input  logic        wr,
  input  logic        rd,
  output logic [15:0] rdata,
  input  logic        tick,
  input  logic        no_reboot,
  output logic        reset_req
);
  localparam int HI = CW - 8;

  logic [CW-1:0] cnt, tmr;
  logic          halt, lock;
  logic          to_flg, smi_flg, int_flg, sec_flg, boot_flg;
  logic [15:0]   ctl_b;
  logic [7:0]    din, dout, swirq, wdc;

  wire any_be = |be;
  wire ld     = wr && addr == 3'd0 && any_be;
  wire expire = tick && !halt && !ld && cnt <= CW'(1);
  wire sec_ev = expire && to_flg;
  wire boot_ev = sec_ev && !no_reboot;
  wire wa2    = wr && addr == 3'd2 && be[0];
  wire wa3    = wr && addr == 3'd3 && be[0];
  wire smi_ev = wr && addr == 3'd6 && be[0];
  wire int_ev = wr && addr == 3'd6 && be[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (ld) cnt <= tmr;
    else if (expire) cnt <= tmr;
    else if (tick && !halt) cnt <= cnt - CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmr   <= CW'(TMR_RST);
      halt  <= 1'b0;
      lock  <= 1'b0;
      ctl_b <= 16'h0008;
      din   <= '0;
      dout  <= '0;
      swirq <= 8'h03;
      wdc   <= '0;
    end else if (wr) begin
      case (addr)
        3'd1: begin
          if (be[0]) tmr[7:0] <= wdata[7:0];
          if (be[1]) tmr[CW-1:8] <= wdata[8 +: HI];
        end
        3'd4: if (be[0]) begin
          halt <= wdata[0];
          lock <= lock | wdata[1];
        end
        3'd5: begin
          if (be[0]) ctl_b[7:0]  <= wdata[7:0];
          if (be[1]) ctl_b[15:8] <= wdata[15:8];
        end
        3'd6: begin
          if (be[0]) din  <= wdata[7:0];
          if (be[1]) dout <= wdata[15:8];
        end
        3'd7: begin
          if (be[0]) swirq <= wdata[7:0];
          if (be[1]) wdc   <= wdata[15:8];
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      to_flg <= 1'b0; smi_flg <= 1'b0; int_flg <= 1'b0;
      sec_flg <= 1'b0; boot_flg <= 1'b0; reset_req <= 1'b0;
    end else begin
      to_flg    <= (to_flg   & ~(wa2 & wdata[0])) | expire;
      smi_flg   <= (smi_flg  & ~(wa2 & wdata[1])) | smi_ev;
      int_flg   <= (int_flg  & ~(wa2 & wdata[2])) | int_ev;
      sec_flg   <= (sec_flg  & ~(wa3 & wdata[0])) | sec_ev;
      boot_flg  <= (boot_flg & ~(wa3 & wdata[1])) | boot_ev;
      reset_req <= boot_ev;
    end

  logic [15:0] rmux;
  always_comb
    case (addr)
      3'd0:    rmux = 16'(cnt);
      3'd1:    rmux = 16'(tmr);
      3'd2:    rmux = {13'd0, int_flg, smi_flg, to_flg};
      3'd3:    rmux = {14'd0, boot_flg, sec_flg};
      3'd4:    rmux = {14'd0, lock, halt};
      3'd5:    rmux = ctl_b;
      3'd6:    rmux = {dout, din};
      default: rmux = {wdc, swirq};
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= '0;
    else if (rd) rdata <= rmux;

  p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !ld) |=> $stable(cnt));
  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  p_req_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> ($past(!no_reboot) && boot_flg));
  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  p_second_after_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_flg) |-> $past(to_flg));
  p_reload_on_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_flg) |-> cnt == tmr);
endmodule

// File: tb/sim_twostage_wdt.sv
module sim_twostage_wdt;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [1:0] be = 0;
  logic wr = 0, rd = 0, tick = 0, no_reboot = 1;
  logic reset_req;
  int checks = 0, errors = 0, req_cycles = 0;

  twostage_wdt u0 (.clk, .rst_n, .addr, .wdata, .be, .wr, .rd, .rdata,
                   .tick, .no_reboot, .reset_req);

  always #4 clk = ~clk;
  always @(negedge clk) if (reset_req) req_cycles++;

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wrw(logic [2:0] a, logic [15:0] d, logic [1:0] b = 2'b11);
    @(negedge clk); addr = a; wdata = d; be = b; wr = 1;
    @(negedge clk); wr = 0; be = 0;
  endtask

  task automatic rdw(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic rchk(string req, logic [2:0] a, logic [15:0] exp);
    logic [15:0] d;
    rdw(a, d);
    chk(req, d, exp);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic t_reset;
    logic [15:0] exp [8] = '{16'h0, 16'h4, 16'h0, 16'h0, 16'h0, 16'h8, 16'h0, 16'h3};
    for (int a = 0; a < 8; a++) rchk("R1", 3'(a), exp[a]);
  endtask

  task automatic t_mask;
    wrw(3'd1, 16'hFFFF);
    rchk("R2", 3'd1, 16'h03FF);
    wrw(3'd1, 16'hFC05);
    rchk("R2", 3'd1, 16'h0005);
  endtask

  task automatic t_count;
    wrw(3'd4, 16'h0001);
    wrw(3'd1, 16'd13);
    wrw(3'd0, 16'h1234);
    rchk("R3", 3'd0, 16'd13);
    ticks(3);
    rchk("R4", 3'd0, 16'd13);
    wrw(3'd4, 16'h0000);
    ticks(5);
    rchk("R5", 3'd0, 16'd8);
    ticks(2);
    rchk("R5", 3'd0, 16'd6);
  endtask

  task automatic t_max;
    wrw(3'd4, 16'h0001);
    wrw(3'd2, 16'h0007);
    wrw(3'd3, 16'h0003);
    wrw(3'd1, 16'h03FF);
    wrw(3'd0, 16'h0000);
    wrw(3'd4, 16'h0000);
    ticks(16'h3FE);
    rchk("R6", 3'd0, 16'd1);
    rchk("R6", 3'd2, 16'h0000);
    ticks(1);
    rchk("R6", 3'd2, 16'h0001);
    rchk("R6", 3'd0, 16'h03FF);
  endtask

  task automatic t_second(logic nr);
    logic [15:0] s;
    wrw(3'd4, 16'h0001);
    wrw(3'd2, 16'h0007);
    wrw(3'd3, 16'h0003);
    wrw(3'd1, 16'd3);
    wrw(3'd0, 16'd0);
    no_reboot = nr;
    req_cycles = 0;
    wrw(3'd4, 16'h0000);
    ticks(3);
    rchk("R6", 3'd2, 16'h0001);
    rchk("R7", 3'd3, 16'h0000);
    ticks(3);
    rchk("R7", 3'd3, nr ? 16'h0001 : 16'h0003);
    chk("R8", 16'(req_cycles), nr ? 16'd0 : 16'd1);
    rdw(3'd3, s); wrw(3'd3, s);
    rchk("R9", 3'd3, 16'h0000);
    wrw(3'd4, 16'h0001);
    rdw(3'd2, s); wrw(3'd2, s);
    rchk("R9", 3'd2, 16'h0000);
  endtask

  task automatic t_data;
    wrw(3'd6, 16'h00A5, 2'b01);
    rchk("R11", 3'd2, 16'h0002);
    wrw(3'd6, 16'h5A00, 2'b10);
    rchk("R11", 3'd2, 16'h0006);
    rchk("R11", 3'd6, 16'h5AA5);
    wrw(3'd2, 16'h0002);
    rchk("R9", 3'd2, 16'h0004);
  endtask

  task automatic t_lock;
    wrw(3'd4, 16'h0003);
    wrw(3'd4, 16'h0000);
    rchk("R10", 3'd4, 16'h0002);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset;
        t_mask;
        t_count;
        t_max;
        t_second(1'b1);
        t_second(1'b0);
        t_data;
        t_lock;
      end
      begin
        repeat (100000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule